// File: doc/BRIEF.md
# USB Pipe DMA Port Controller

This block drives one DMA-facing data port that sits in front of the buffer memory of a USB function or host controller. Software, or a configuration bus, picks which pipe the port serves and how wide each DMA access is. While the buffer of that pipe can be accessed, the block raises a request to the DMA controller. Each completed access moves the running byte count forward by 1, 2 or 4 bytes.

The block can also watch the end-of-transfer strobe that the DMA controller raises after its programmed count. When the selected pipe sends data, the strobe commits the partly filled buffer for transmission. If the total written is a nonzero multiple of the pipe's maximum packet size, the block then asks the serial engine for one extra empty packet. When the selected pipe receives data, the block can clear the pipe buffer by itself once the received packet has been fully read. It can do this either on the data alone or only after an extra read-complete handshake. The buffer memory and the serial engine are outside the block and are seen only through status and pulse signals.

Top module: `usb_dma_port_ctrl`

## Requirements
- R1: After reset, `xfer_active`, `byte_cnt`, `sel_pipe`, `buf_commit`, `zlp_send` and `buf_clear` are 0. Any pending empty-packet request is discarded, so a later `tx_accepted` gives no `zlp_send`.
- R2: `dma_req` equals `buf_ready[sel_pipe]` when `sel_pipe` is 1..7. `dma_req` is always 0 when pipe 0 is selected.
- R3: A `cfg_wr` pulse loads the width code and the mode bits at any time. It loads `cfg_pipe` into `sel_pipe` only while `xfer_active` is 0; otherwise the pipe field is ignored.
- R4: Each `dma_ack` cycle adds the access width to `byte_cnt` and sets `xfer_active`. Width code 0 adds 1 byte, code 1 adds 2 bytes, and codes 2 and 3 add 4 bytes.
- R5: With the end-sampling enable at 0, `dma_end` is ignored: no `buf_commit`, and `byte_cnt` and `xfer_active` keep their values.
- R6: With end sampling enabled, `dma_end` clears `byte_cnt` and `xfer_active` at the next edge. If the selected pipe transmits (`pipe_is_tx[sel_pipe]` = 1), it also gives a one-cycle `buf_commit` pulse in the cycle after the strobe.
- R7: With empty-packet mode on, a sampled end strobe on a transmit pipe queues one empty packet when the total byte count, including an access in the same cycle, is nonzero and an exact multiple of that pipe's maximum packet size (`pipe_mps[p*9 +: 9]`). The first `tx_accepted` after that yields exactly one `zlp_send` pulse in the following cycle.
- R8: Empty-packet mode has no effect on a receive pipe, and on a receive pipe `dma_end` gives no `buf_commit`. Auto-clear mode has no effect on a transmit pipe.
- R9: With auto-clear on, read mode 0 and a receive pipe, `rx_load` loads the remaining count from `rx_len`, and each `dma_ack` lowers it by the access width, stopping at 0. One cycle after the count is 0, `buf_clear` pulses once.
- R10: With read mode 1, the clear also waits for an `rd_done` pulse seen since the last `rx_load`, in either order. `buf_clear` pulses one cycle after both conditions hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_pipe | input | 3 | Pipe to select |
| cfg_width | input | 2 | Access width code |
| cfg_end_en | input | 1 | Sample the end-of-transfer strobe |
| cfg_zlp_en | input | 1 | Empty-packet mode |
| cfg_autoclr_en | input | 1 | Auto-clear mode |
| cfg_rdmode | input | 1 | Read mode: 1 requires the read-complete handshake |
| pipe_is_tx | input | 8 | Per-pipe direction, 1 = transmit |
| pipe_mps | input | 72 | Per-pipe maximum packet size, 9 bits each |
| buf_ready | input | 8 | Per-pipe buffer accessible |
| dma_ack | input | 1 | One DMA access done this cycle |
| dma_end | input | 1 | End-of-transfer strobe from the DMA controller |
| dma_req | output | 1 | DMA request |
| tx_accepted | input | 1 | Serial engine took the committed buffer |
| rx_load | input | 1 | Received packet landed in the buffer |
| rx_len | input | 11 | Length of the received packet in bytes |
| rd_done | input | 1 | Read-complete handshake |
| sel_pipe | output | 3 | Currently selected pipe |
| xfer_active | output | 1 | A DMA transfer is in progress |
| byte_cnt | output | 16 | Bytes moved since the last sampled end |
| buf_commit | output | 1 | Mark the transmit buffer valid |
| zlp_send | output | 1 | Send one empty packet |
| buf_clear | output | 1 | Clear the selected pipe buffer |

## Verification
The hardest case to reach is an end strobe that lands exactly on a multiple of the packet size for pipes whose sizes are not powers of two. Getting there needs the right width, access count and pipe together. The stimulus draws random pipes, widths and access counts whose products often hit multiples of the per-pipe sizes, and adds directed runs that hit the boundary exactly and miss it by one access. A queued empty packet that is wiped by reset is reached by directed stimulus before the accept pulse arrives.

// File: rtl/usb_dma_port_pkg.sv
package usb_dma_port_pkg;

  typedef enum logic [1:0] {
    ACC_BYTE  = 2'd0,
    ACC_HALF  = 2'd1,
    ACC_WORD  = 2'd2,
    ACC_WORDX = 2'd3
  } acc_width_e;

  function automatic logic [2:0] width_bytes(input acc_width_e code);
    case (code)
      ACC_BYTE: return 3'd1;
      ACC_HALF: return 3'd2;
      default:  return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/usb_dma_port_cfg.sv
module usb_dma_port_cfg
  import usb_dma_port_pkg::*;
#(
  parameter int PIPE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [PIPE_W-1:0] cfg_pipe,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_end_en,
  input  logic              cfg_zlp_en,
  input  logic              cfg_autoclr_en,
  input  logic              cfg_rdmode,
  input  logic              xfer_active,
  output logic [PIPE_W-1:0] sel_pipe,
  output acc_width_e        width,
  output logic              end_en,
  output logic              zlp_en,
  output logic              autoclr_en,
  output logic              rdmode
);

  logic [PIPE_W-1:0] pipe_n;
  acc_width_e        width_n;
  logic              end_en_n, zlp_en_n, autoclr_n, rdmode_n;

  always_comb begin
    pipe_n    = sel_pipe;
    width_n   = width;
    end_en_n  = end_en;
    zlp_en_n  = zlp_en;
    autoclr_n = autoclr_en;
    rdmode_n  = rdmode;
    if (cfg_wr) begin
      if (!xfer_active) pipe_n = cfg_pipe;
      width_n   = acc_width_e'(cfg_width);
      end_en_n  = cfg_end_en;
      zlp_en_n  = cfg_zlp_en;
      autoclr_n = cfg_autoclr_en;
      rdmode_n  = cfg_rdmode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_pipe   <= '0;
      width      <= ACC_BYTE;
      end_en     <= 1'b0;
      zlp_en     <= 1'b0;
      autoclr_en <= 1'b0;
      rdmode     <= 1'b0;
    end else begin
      sel_pipe   <= pipe_n;
      width      <= width_n;
      end_en     <= end_en_n;
      zlp_en     <= zlp_en_n;
      autoclr_en <= autoclr_n;
      rdmode     <= rdmode_n;
    end
  end

  AST_PIPE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_active |=> $stable(sel_pipe)); // R3

endmodule

// File: rtl/usb_dma_xfer_count.sv
module usb_dma_xfer_count #(
  parameter int MPS_W = 9,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack,
  input  logic             end_fire,
  input  logic [2:0]       w_bytes,
  input  logic [MPS_W-1:0] mps,
  input  logic             dir_tx,
  input  logic             zlp_en,
  input  logic             tx_accepted,
  output logic             active,
  output logic [CNT_W-1:0] byte_cnt,
  output logic             commit,
  output logic             zlp_send
);

  localparam int SUM_W = MPS_W + 1;

  logic [MPS_W-1:0] rem_q, rem_n;
  logic [SUM_W-1:0] rem_sum, rem_add;
  logic [CNT_W-1:0] cnt_add, cnt_n;
  logic             act_n, commit_n, pend_q, pend_n, send_n, zlp_hit;

  always_comb begin
    rem_sum = {1'b0, rem_q} + SUM_W'(w_bytes);
    if (!ack)                         rem_add = {1'b0, rem_q};
    else if (rem_sum >= {1'b0, mps})  rem_add = rem_sum - {1'b0, mps};
    else                              rem_add = rem_sum;
    cnt_add = ack ? byte_cnt + CNT_W'(w_bytes) : byte_cnt;
    zlp_hit = end_fire && dir_tx && zlp_en && (cnt_add != '0)
              && (rem_add[MPS_W-1:0] == '0);

    cnt_n = cnt_add;
    rem_n = rem_add[MPS_W-1:0];
    act_n = active | ack;
    if (end_fire) begin
      cnt_n = '0;
      rem_n = '0;
      act_n = 1'b0;
    end
    commit_n = end_fire && dir_tx;

    pend_n = pend_q;
    if (zlp_hit)                    pend_n = 1'b1;
    else if (pend_q && tx_accepted) pend_n = 1'b0;
    send_n = pend_q && tx_accepted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q    <= '0;
      byte_cnt <= '0;
      active   <= 1'b0;
      commit   <= 1'b0;
      pend_q   <= 1'b0;
      zlp_send <= 1'b0;
    end else begin
      rem_q    <= rem_n;
      byte_cnt <= cnt_n;
      active   <= act_n;
      commit   <= commit_n;
      pend_q   <= pend_n;
      zlp_send <= send_n;
    end
  end

  AST_COMMIT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(end_fire && dir_tx)); // R6
  AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    end_fire |=> (byte_cnt == '0 && !active)); // R6
  AST_ZLP_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    zlp_send |-> $past(tx_accepted)); // R7
  AST_ACK_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !end_fire) |=> active); // R4

endmodule

// File: rtl/usb_dma_rx_clear.sv
module usb_dma_rx_clear #(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_load,
  input  logic [LEN_W-1:0] rx_len,
  input  logic             ack,
  input  logic [2:0]       w_bytes,
  input  logic             dir_tx,
  input  logic             autoclr_en,
  input  logic             rdmode,
  input  logic             rd_done,
  output logic             buf_clear
);

  logic             loaded_q, loaded_n, done_q, done_n, fire;
  logic [LEN_W-1:0] left_q, left_n;

  always_comb begin
    fire = loaded_q && (left_q == '0) && autoclr_en && !dir_tx
           && (!rdmode || done_q);
    loaded_n = loaded_q;
    left_n   = left_q;
    done_n   = done_q;
    if (rx_load) begin
      loaded_n = 1'b1;
      left_n   = rx_len;
      done_n   = 1'b0;
    end else begin
      if (fire) loaded_n = 1'b0;
      if (loaded_q && rd_done) done_n = 1'b1;
      if (loaded_q && ack && !dir_tx)
        left_n = (left_q > LEN_W'(w_bytes)) ? left_q - LEN_W'(w_bytes) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q  <= 1'b0;
      left_q    <= '0;
      done_q    <= 1'b0;
      buf_clear <= 1'b0;
    end else begin
      loaded_q  <= loaded_n;
      left_q    <= left_n;
      done_q    <= done_n;
      buf_clear <= fire;
    end
  end

  AST_CLR_RX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    buf_clear |-> $past(!dir_tx && autoclr_en)); // R8
  AST_CLR_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_clear && $past(rdmode)) |-> $past(done_q)); // R10
  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_clear && !$past(rx_load)) |-> !loaded_q); // R9

endmodule

// File: rtl/usb_dma_port_ctrl.sv
module usb_dma_port_ctrl
  import usb_dma_port_pkg::*;
#(
  parameter int NPIPE  = 8,
  parameter int MPS_W  = 9,
  parameter int CNT_W  = 16,
  parameter int LEN_W  = 11,
  localparam int PIPE_W = $clog2(NPIPE)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_wr,
  input  logic [PIPE_W-1:0]      cfg_pipe,
  input  logic [1:0]             cfg_width,
  input  logic                   cfg_end_en,
  input  logic                   cfg_zlp_en,
  input  logic                   cfg_autoclr_en,
  input  logic                   cfg_rdmode,
  input  logic [NPIPE-1:0]       pipe_is_tx,
  input  logic [NPIPE*MPS_W-1:0] pipe_mps,
  input  logic [NPIPE-1:0]       buf_ready,
  input  logic                   dma_ack,
  input  logic                   dma_end,
  output logic                   dma_req,
  input  logic                   tx_accepted,
  input  logic                   rx_load,
  input  logic [LEN_W-1:0]       rx_len,
  input  logic                   rd_done,
  output logic [PIPE_W-1:0]      sel_pipe,
  output logic                   xfer_active,
  output logic [CNT_W-1:0]       byte_cnt,
  output logic                   buf_commit,
  output logic                   zlp_send,
  output logic                   buf_clear
);

  logic [1:0] rst_sync;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  acc_width_e       width;
  logic             end_en, zlp_en, autoclr_en, rdmode;
  logic [2:0]       w_bytes;
  logic [MPS_W-1:0] mps_sel;
  logic             dir_tx, end_fire;

  usb_dma_port_cfg #(.PIPE_W(PIPE_W)) u_cfg (
    .clk(clk), .rst_n(rst_n_s), .cfg_wr(cfg_wr), .cfg_pipe(cfg_pipe),
    .cfg_width(cfg_width), .cfg_end_en(cfg_end_en), .cfg_zlp_en(cfg_zlp_en),
    .cfg_autoclr_en(cfg_autoclr_en), .cfg_rdmode(cfg_rdmode),
    .xfer_active(xfer_active), .sel_pipe(sel_pipe), .width(width),
    .end_en(end_en), .zlp_en(zlp_en), .autoclr_en(autoclr_en), .rdmode(rdmode)
  );

  always_comb begin
    w_bytes  = width_bytes(width);
    mps_sel  = pipe_mps[sel_pipe*MPS_W +: MPS_W];
    dir_tx   = pipe_is_tx[sel_pipe];
    end_fire = end_en && dma_end;
    dma_req  = (sel_pipe != '0) && buf_ready[sel_pipe];
  end

  usb_dma_xfer_count #(.MPS_W(MPS_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_s), .ack(dma_ack), .end_fire(end_fire),
    .w_bytes(w_bytes), .mps(mps_sel), .dir_tx(dir_tx), .zlp_en(zlp_en),
    .tx_accepted(tx_accepted), .active(xfer_active), .byte_cnt(byte_cnt),
    .commit(buf_commit), .zlp_send(zlp_send)
  );

  usb_dma_rx_clear #(.LEN_W(LEN_W)) u_rx (
    .clk(clk), .rst_n(rst_n_s), .rx_load(rx_load), .rx_len(rx_len),
    .ack(dma_ack), .w_bytes(w_bytes), .dir_tx(dir_tx),
    .autoclr_en(autoclr_en), .rdmode(rdmode), .rd_done(rd_done),
    .buf_clear(buf_clear)
  );

  AST_NO_REQ_PIPE0: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sel_pipe == '0) |-> !dma_req); // R2
  AST_ENDOFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!end_en && !dma_ack && !cfg_wr) |=> ($stable(byte_cnt) && !buf_commit)); // R5

endmodule

// File: tb/usb_dma_port_ctrl_tb.sv
module usb_dma_port_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr, cfg_end_en, cfg_zlp_en, cfg_autoclr_en, cfg_rdmode;
  logic [2:0]  cfg_pipe;
  logic [1:0]  cfg_width;
  logic [7:0]  pipe_is_tx, buf_ready;
  logic [71:0] pipe_mps;
  logic        dma_ack, dma_end, dma_req, tx_accepted, rx_load, rd_done;
  logic [10:0] rx_len;
  logic [2:0]  sel_pipe;
  logic        xfer_active, buf_commit, zlp_send, buf_clear;
  logic [15:0] byte_cnt;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  usb_dma_port_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_pipe(cfg_pipe),
    .cfg_width(cfg_width), .cfg_end_en(cfg_end_en), .cfg_zlp_en(cfg_zlp_en),
    .cfg_autoclr_en(cfg_autoclr_en), .cfg_rdmode(cfg_rdmode),
    .pipe_is_tx(pipe_is_tx), .pipe_mps(pipe_mps), .buf_ready(buf_ready),
    .dma_ack(dma_ack), .dma_end(dma_end), .dma_req(dma_req),
    .tx_accepted(tx_accepted), .rx_load(rx_load), .rx_len(rx_len),
    .rd_done(rd_done), .sel_pipe(sel_pipe), .xfer_active(xfer_active),
    .byte_cnt(byte_cnt), .buf_commit(buf_commit), .zlp_send(zlp_send),
    .buf_clear(buf_clear)
  );

  function automatic int mps_of(input int p);
    return 4 * p + 4;
  endfunction

  function automatic int wb(input int code);
    return (code == 0) ? 1 : (code == 1) ? 2 : 4;
  endfunction

  function automatic bit zlp_expected(input int total, input int mps, input bit en);
    return en && (total != 0) && (total % mps == 0);
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_cfg(input int p, input int w, input bit ee, input bit ze,
                         input bit ac, input bit rm);
    cfg_wr = 1; cfg_pipe = 3'(p); cfg_width = 2'(w);
    cfg_end_en = ee; cfg_zlp_en = ze; cfg_autoclr_en = ac; cfg_rdmode = rm;
    step();
    cfg_wr = 0;
  endtask

  task automatic acks(input int n);
    for (int i = 0; i < n; i++) begin
      dma_ack = 1;
      step();
    end
    dma_ack = 0;
  endtask

  task automatic end_pulse();
    dma_end = 1;
    step();
    dma_end = 0;
  endtask

  task automatic accept_pulse();
    tx_accepted = 1;
    step();
    tx_accepted = 0;
  endtask

  task automatic tx_run(input int p, input int w, input int n, input bit ze);
    int  total;
    bit  exp_z;
    total = n * wb(w);
    exp_z = zlp_expected(total, mps_of(p), ze);
    set_cfg(p, w, 1, ze, 0, 0);
    acks(n);
    check("R4 byte count", byte_cnt, total);
    check("R4 active", xfer_active, (n > 0) ? 1 : 0);
    end_pulse();
    check("R6 commit pulse", buf_commit, 1);
    check("R6 count cleared", byte_cnt, 0);
    check("R6 active cleared", xfer_active, 0);
    step();
    check("R6 commit one cycle", buf_commit, 0);
    accept_pulse();
    check("R7 empty packet", zlp_send, exp_z);
    accept_pulse();
    check("R7 only once", zlp_send, 0);
  endtask

  task automatic rx_run(input int p, input int w, input int len);
    int n;
    n = (len + wb(w) - 1) / wb(w);
    set_cfg(p, w, 1, 0, 1, 0);
    rx_len = 11'(len); rx_load = 1;
    step();
    rx_load = 0;
    for (int i = 0; i < n; i++) begin
      check("R9 no early clear", buf_clear, 0);
      dma_ack = 1;
      step();
      dma_ack = 0;
    end
    check("R9 clear not yet", buf_clear, 0);
    step();
    check("R9 clear pulse", buf_clear, 1);
    step();
    check("R9 clear one cycle", buf_clear, 0);
    end_pulse();
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int p = 0; p < 8; p++) pipe_mps[p*9 +: 9] = 9'(mps_of(p));
    pipe_is_tx = 8'b0001_1110;
    buf_ready = 8'h00;
    cfg_wr = 0; cfg_pipe = 0; cfg_width = 0; cfg_end_en = 0; cfg_zlp_en = 0;
    cfg_autoclr_en = 0; cfg_rdmode = 0; dma_ack = 0; dma_end = 0;
    tx_accepted = 0; rx_load = 0; rx_len = 0; rd_done = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) step();

    // R1 reset state
    check("R1 active", xfer_active, 0);
    check("R1 byte_cnt", byte_cnt, 0);
    check("R1 sel_pipe", sel_pipe, 0);
    check("R1 pulses", {buf_commit, zlp_send, buf_clear}, 0);

    // R2 request follows selected pipe buffer status
    for (int i = 0; i < 40; i++) begin
      int p;
      p = (i < 8) ? i : int'($urandom_range(0, 7));
      set_cfg(p, 0, 1, 0, 0, 0);
      buf_ready = 8'($urandom);
      #1;
      check("R2 request", dma_req, (p != 0) ? int'(buf_ready[p]) : 0);
    end
    buf_ready = 8'hFF;
    set_cfg(0, 0, 1, 0, 0, 0);
    #1 check("R2 pipe0 all ready", dma_req, 0);

    // R3 pipe select locked while active, width still loads
    set_cfg(1, 0, 1, 0, 0, 0);
    acks(1);
    set_cfg(3, 1, 1, 0, 0, 0);
    check("R3 pipe held", sel_pipe, 1);
    acks(1);
    check("R3 width loads while active", byte_cnt, 3);
    end_pulse();
    step();
    set_cfg(3, 1, 1, 0, 0, 0);
    check("R3 pipe loads when idle", sel_pipe, 3);

    // R4 width code 3 counts as 4 bytes
    set_cfg(2, 3, 1, 0, 0, 0);
    acks(3);
    check("R4 code 3", byte_cnt, 12);
    end_pulse();
    step();

    // R5 end strobe ignored when sampling off
    set_cfg(1, 1, 0, 1, 0, 0);
    acks(4);
    end_pulse();
    check("R5 no commit", buf_commit, 0);
    check("R5 count kept", byte_cnt, 8);
    check("R5 active kept", xfer_active, 1);
    accept_pulse();
    check("R5 no empty packet", zlp_send, 0);
    set_cfg(1, 1, 1, 1, 0, 0);
    end_pulse();
    check("R6 late end commits", buf_commit, 1);
    step();
    accept_pulse();
    check("R7 after enable", zlp_send, 1);

    // R6/R7 directed: exact multiple and one access short
    tx_run(1, 2, 2, 1);
    tx_run(2, 0, 11, 1);
    tx_run(2, 0, 12, 1);
    tx_run(3, 2, 4, 0);
    tx_run(4, 1, 0, 1);

    // R7 access in the same cycle as the end strobe is counted
    set_cfg(1, 2, 1, 1, 0, 0);
    acks(1);
    dma_ack = 1; dma_end = 1;
    step();
    dma_ack = 0; dma_end = 0;
    step();
    accept_pulse();
    check("R7 same-cycle access", zlp_send, 1);

    // R6/R7 random transmit runs
    for (int i = 0; i < 30; i++)
      tx_run(int'($urandom_range(1, 4)), int'($urandom_range(0, 3)),
             int'($urandom_range(0, 16)), 1'($urandom));

    // R8 receive pipe: no commit, no empty packet
    set_cfg(5, 2, 1, 1, 0, 0);
    acks(6);
    end_pulse();
    check("R8 rx no commit", buf_commit, 0);
    accept_pulse();
    check("R8 rx no empty packet", zlp_send, 0);

    // R9 directed and random receive runs
    rx_run(6, 1, 6);
    rx_run(5, 2, 0);
    rx_run(7, 2, 7);
    for (int i = 0; i < 20; i++)
      rx_run(int'($urandom_range(5, 7)), int'($urandom_range(0, 3)),
             int'($urandom_range(0, 40)));

    // R10 handshake after data drained
    set_cfg(6, 1, 1, 0, 1, 1);
    rx_len = 4; rx_load = 1; step(); rx_load = 0;
    acks(2);
    repeat (3) step();
    check("R10 waits for handshake", buf_clear, 0);
    rd_done = 1; step(); rd_done = 0;
    check("R10 not same cycle", buf_clear, 0);
    step();
    check("R10 clear after handshake", buf_clear, 1);
    end_pulse();

    // R10 handshake before data drained
    rx_len = 4; rx_load = 1; step(); rx_load = 0;
    rd_done = 1; step(); rd_done = 0;
    acks(1);
    step();
    check("R10 early handshake partial", buf_clear, 0);
    acks(1);
    step();
    check("R10 early handshake clear", buf_clear, 1);
    end_pulse();

    // R8 auto-clear ignored on transmit pipe
    set_cfg(1, 0, 1, 0, 1, 0);
    rx_len = 0; rx_load = 1; step(); rx_load = 0;
    step();
    check("R8 tx no clear", buf_clear, 0);
    step();
    check("R8 tx no clear later", buf_clear, 0);

    // R1 reset discards a queued empty packet
    set_cfg(1, 2, 1, 1, 0, 0);
    acks(2);
    end_pulse();
    rst_n = 0;
    step();
    rst_n = 1;
    repeat (3) step();
    check("R1 sel after reset", sel_pipe, 0);
    set_cfg(1, 2, 1, 1, 0, 0);
    accept_pulse();
    check("R1 pending dropped", zlp_send, 0);
    check("R1 count after reset", byte_cnt, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule